// File: doc/BRIEF.md
# N+1 Redundant Channel Steering Controller

This block sits in front of a bank of deserializer channels. It takes one serial input per primary channel plus one spare serial input, and decides which serial bit each channel's deserializer core sees. A small select code names the primary channel that the spare input replaces. The primary input displaced by that choice is not dropped. It goes, undecoded, to a single monitor output. This lets a faulty or suspect link still be probed at low speed while the spare carries its traffic.

Two further select codes leave every primary on its own channel. One of them turns the monitor off. The other points the monitor at the spare input. The select code is captured on the word clock, so the routing only changes at a clock edge. The block also produces the output enables for the pins downstream. A global power control disables everything. A global output enable disables data, clock and monitor pins but keeps the lock pins driven. A per-channel lock flag disables that channel's data and recovered-clock pins while the channel is unlocked. High impedance is shown as explicit enable signals, not as tri-state logic.

Top module: `redundancy_steer`

## Requirements
- R1: While reset is asserted, the routing is in the monitor-off state: `chan_out` equals `prim_in` and `mon_oe` is 0, whatever `route_sel` is.
- R2: With an effective select value n in 0..5, `chan_out[n]` carries `spare_in`, every other channel carries its own primary input, and `mon_out` carries `prim_in[n]`. At most one channel ever differs from its primary input.
- R3: Select value 6 routes every primary to its own channel and ignores the spare. `mon_out` is 0 and `mon_oe` is 0.
- R4: Select value 7 routes every primary to its own channel, and `mon_out` carries `spare_in`.
- R5: A new `route_sel` value takes effect only at the next rising edge of `clk`. Before that edge the outputs follow the previous select.
- R6: When `pwr_on` is 0, `data_oe`, `lock_oe` and `mon_oe` are all 0.
- R7: When `pwr_on` is 1 and `out_en` is 0, `data_oe` and `mon_oe` are 0 and `lock_oe` is 1.
- R8: `data_oe[i]` is 0 whenever `lock_n[i]` is 1. Other channels are not affected.
- R9: When `out_en` returns to 1 with the other controls unchanged, the enables and routing come back exactly as before, with no reprogramming of the select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prim_in | input | 6 | Primary serial inputs, one per channel |
| spare_in | input | 1 | Spare serial input |
| route_sel | input | 3 | Substitution / monitor select code |
| pwr_on | input | 1 | 1 = active, 0 = powered down |
| out_en | input | 1 | Global enable for data, clock and monitor pins |
| lock_n | input | 6 | Per-channel lock flag, 1 = unlocked |
| chan_out | output | 6 | Serial bit steered into each channel core |
| mon_out | output | 1 | Monitor serial bit |
| mon_oe | output | 1 | Monitor pin enable |
| data_oe | output | 6 | Per-channel enable for data and recovered-clock pins |
| lock_oe | output | 1 | Enable for the lock pins |

## Verification
The bench drives each substitution code with a primary pattern whose bits differ from the spare, so a swapped index or an off-by-one select decode shows up as the wrong channel carrying the spare, or as the wrong primary reaching the monitor. The two special codes are checked for a monitor left enabled on the off code, or a spare that leaks into a channel on the monitor-spare code. The select is changed half a cycle before an edge and sampled at once, which catches a select that is not registered. Enable checks separate the power and output-enable paths, so lock enables that follow `out_en` are caught. They also set lock on only some channels, so gating applied to the wrong channel is caught. Restoring `out_en` after a disable catches a design that loses its routing along the way.

// File: rtl/steer_pkg.sv
package steer_pkg;
  // width of the select code: primaries plus two special codes
  function automatic int unsigned sel_width(input int unsigned nch);
    return $clog2(nch + 2);
  endfunction

  // code meaning "no substitution, monitor off"
  function automatic int unsigned code_off(input int unsigned nch);
    return nch;
  endfunction

  // code meaning "no substitution, monitor watches the spare"
  function automatic int unsigned code_spare(input int unsigned nch);
    return nch + 1;
  endfunction
endpackage

// File: rtl/steer_rst_sync.sv
module steer_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;
endmodule

// File: rtl/steer_sel_reg.sv
module steer_sel_reg #(
  parameter int unsigned NUM_CH = 6,
  localparam int unsigned SEL_W = steer_pkg::sel_width(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_in,
  output logic [SEL_W-1:0] sel_q
);
  localparam logic [SEL_W-1:0] SEL_RST = SEL_W'(steer_pkg::code_off(NUM_CH));

  logic             load_en;
  logic [SEL_W-1:0] sel_d;

  always_comb begin
    load_en = (sel_in != sel_q);
    sel_d   = sel_q;
    if (load_en) begin
      sel_d = sel_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SEL_RST;
    end else if (load_en) begin
      sel_q <= sel_d;
    end
  end
endmodule

// File: rtl/steer_mux.sv
module steer_mux #(
  parameter int unsigned NUM_CH = 6,
  localparam int unsigned SEL_W = steer_pkg::sel_width(NUM_CH)
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [NUM_CH-1:0] prim_in,
  input  logic              spare_in,
  output logic [NUM_CH-1:0] chan_out,
  output logic              mon_out,
  output logic              mon_act
);
  localparam logic [SEL_W-1:0] SEL_SPARE = SEL_W'(steer_pkg::code_spare(NUM_CH));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    assign chan_out[g] = (sel == SEL_W'(g)) ? spare_in : prim_in[g];
  end

  always_comb begin
    mon_out = 1'b0;
    mon_act = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (sel == SEL_W'(i)) begin
        mon_out = prim_in[i];
        mon_act = 1'b1;
      end
    end
    if (sel == SEL_SPARE) begin
      mon_out = spare_in;
      mon_act = 1'b1;
    end
  end
endmodule

// File: rtl/steer_oe_gate.sv
module steer_oe_gate #(
  parameter int unsigned NUM_CH = 6
) (
  input  logic              pwr_on,
  input  logic              out_en,
  input  logic [NUM_CH-1:0] lock_n,
  input  logic              mon_act,
  output logic [NUM_CH-1:0] data_oe,
  output logic              mon_oe,
  output logic              lock_oe
);
  logic glob_en;

  always_comb begin
    glob_en = pwr_on & out_en;
    lock_oe = pwr_on;
    mon_oe  = glob_en & mon_act;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_oe
    assign data_oe[g] = glob_en & ~lock_n[g];
  end
endmodule

// File: rtl/redundancy_steer.sv
module redundancy_steer #(
  parameter int unsigned NUM_CH = 6,
  localparam int unsigned SEL_W = steer_pkg::sel_width(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] prim_in,
  input  logic              spare_in,
  input  logic [SEL_W-1:0]  route_sel,
  input  logic              pwr_on,
  input  logic              out_en,
  input  logic [NUM_CH-1:0] lock_n,
  output logic [NUM_CH-1:0] chan_out,
  output logic              mon_out,
  output logic              mon_oe,
  output logic [NUM_CH-1:0] data_oe,
  output logic              lock_oe
);
  logic             rst_n_sync;
  logic [SEL_W-1:0] sel_q;
  logic             mon_act;

  steer_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  steer_sel_reg #(.NUM_CH(NUM_CH)) u_sel (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .sel_in (route_sel),
    .sel_q  (sel_q)
  );

  steer_mux #(.NUM_CH(NUM_CH)) u_mux (
    .sel      (sel_q),
    .prim_in  (prim_in),
    .spare_in (spare_in),
    .chan_out (chan_out),
    .mon_out  (mon_out),
    .mon_act  (mon_act)
  );

  steer_oe_gate #(.NUM_CH(NUM_CH)) u_oe (
    .pwr_on  (pwr_on),
    .out_en  (out_en),
    .lock_n  (lock_n),
    .mon_act (mon_act),
    .data_oe (data_oe),
    .mon_oe  (mon_oe),
    .lock_oe (lock_oe)
  );
endmodule

// File: rtl/steer_chk.sv
module steer_chk #(
  parameter int unsigned NUM_CH = 6,
  localparam int unsigned SEL_W = steer_pkg::sel_width(NUM_CH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] prim_in,
  input logic              spare_in,
  input logic [SEL_W-1:0]  route_sel,
  input logic              pwr_on,
  input logic              out_en,
  input logic [NUM_CH-1:0] lock_n,
  input logic [NUM_CH-1:0] chan_out,
  input logic              mon_out,
  input logic              mon_oe,
  input logic [NUM_CH-1:0] data_oe,
  input logic              lock_oe
);
  localparam logic [SEL_W-1:0] C_OFF   = SEL_W'(steer_pkg::code_off(NUM_CH));
  localparam logic [SEL_W-1:0] C_SPARE = SEL_W'(steer_pkg::code_spare(NUM_CH));

  logic past_valid;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_valid <= 1'b0;
    else        past_valid <= 1'b1;
  end

  assert_single_sub_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(chan_out ^ prim_in) <= 1);

  assert_off_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && $past(route_sel) == C_OFF) |-> (!mon_oe && chan_out == prim_in));

  assert_spare_mon_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && $past(route_sel) == C_SPARE) |-> (mon_out == spare_in && chan_out == prim_in));

  assert_pwr_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |-> (!lock_oe && data_oe == '0 && !mon_oe));

  assert_out_dis_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on && !out_en) |-> (lock_oe && data_oe == '0 && !mon_oe));

  assert_unlock_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe & lock_n) == '0);
endmodule

bind redundancy_steer steer_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .prim_in   (prim_in),
  .spare_in  (spare_in),
  .route_sel (route_sel),
  .pwr_on    (pwr_on),
  .out_en    (out_en),
  .lock_n    (lock_n),
  .chan_out  (chan_out),
  .mon_out   (mon_out),
  .mon_oe    (mon_oe),
  .data_oe   (data_oe),
  .lock_oe   (lock_oe)
);

// File: tb/tb_redundancy_steer.sv
module tb_redundancy_steer;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 6;

  typedef struct {
    string      tag;
    logic [5:0] ch;
    logic       mon;
    logic       moe;
    logic [5:0] doe;
    logic       loe;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] prim_in;
  logic       spare_in;
  logic [2:0] route_sel;
  logic       pwr_on;
  logic       out_en;
  logic [5:0] lock_n;
  logic [5:0] chan_out;
  logic       mon_out;
  logic       mon_oe;
  logic [5:0] data_oe;
  logic       lock_oe;

  int   n_checks = 0;
  int   n_fails  = 0;
  int   cur_sel  = 6;
  bit   done     = 0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  redundancy_steer dut (
    .clk(clk), .rst_n(rst_n), .prim_in(prim_in), .spare_in(spare_in),
    .route_sel(route_sel), .pwr_on(pwr_on), .out_en(out_en), .lock_n(lock_n),
    .chan_out(chan_out), .mon_out(mon_out), .mon_oe(mon_oe),
    .data_oe(data_oe), .lock_oe(lock_oe)
  );

  function automatic exp_t model(string tag, int sel, logic [5:0] p, logic s,
                                 logic pw, logic oe, logic [5:0] ln);
    exp_t e;
    logic act;
    e.tag = tag;
    e.ch  = p;
    e.mon = 1'b0;
    act   = 1'b0;
    if (sel < NCH) begin
      e.ch[sel] = s;
      e.mon     = p[sel];
      act       = 1'b1;
    end else if (sel == NCH + 1) begin
      e.mon = s;
      act   = 1'b1;
    end
    e.loe = pw;
    e.moe = pw & oe & act;
    e.doe = (pw & oe) ? ~ln : 6'b0;
    return e;
  endfunction

  task automatic compare(exp_t e);
    n_checks++;
    if (chan_out !== e.ch || mon_out !== e.mon || mon_oe !== e.moe ||
        data_oe !== e.doe || lock_oe !== e.loe) begin
      n_fails++;
      $display("FAIL %s: got ch=%b mon=%b moe=%b doe=%b loe=%b exp ch=%b mon=%b moe=%b doe=%b loe=%b",
               e.tag, chan_out, mon_out, mon_oe, data_oe, lock_oe,
               e.ch, e.mon, e.moe, e.doe, e.loe);
    end
  endtask

  // driver: apply one vector at a falling edge, push its expected result
  task automatic apply(string tag, int sel, logic [5:0] p, logic s,
                       logic pw, logic oe, logic [5:0] ln);
    @(negedge clk);
    route_sel = 3'(sel);
    prim_in   = p;
    spare_in  = s;
    pwr_on    = pw;
    out_en    = oe;
    lock_n    = ln;
    sb.push_back(model(tag, sel, p, s, pw, oe, ln));
    cur_sel = sel;
  endtask

  // R5: change select, check at once that the old routing still holds
  task automatic latency_check(int new_sel);
    @(negedge clk);
    route_sel = 3'(new_sel);
    #1;
    compare(model("R5 before edge", cur_sel, prim_in, spare_in, pwr_on, out_en, lock_n));
  endtask

  // monitor: pop and compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) compare(sb.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; route_sel = 3'd0; prim_in = 6'h2A; spare_in = 1'b1;
    pwr_on = 1'b1; out_en = 1'b1; lock_n = 6'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset holds the monitor-off routing even with select 0 driven
    compare(model("R1 reset", 6, prim_in, spare_in, 1'b1, 1'b1, 6'b0));
    @(negedge clk);
    route_sel = 3'd6;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    for (int n = 0; n < 6; n++)
      apply("R2 substitute", n, 6'h15, 1'b1, 1'b1, 1'b1, 6'b0);
    for (int n = 0; n < 6; n++)
      apply("R2 substitute inv", n, 6'h2A, 1'b0, 1'b1, 1'b1, 6'b0);
    apply("R3 monitor off", 6, 6'h3F, 1'b0, 1'b1, 1'b1, 6'b0);
    apply("R3 spare ignored", 6, 6'h0C, 1'b1, 1'b1, 1'b1, 6'b0);
    apply("R4 monitor spare", 7, 6'h3F, 1'b0, 1'b1, 1'b1, 6'b0);
    apply("R4 monitor spare", 7, 6'h00, 1'b1, 1'b1, 1'b1, 6'b0);
    latency_check(2);
    apply("R5 after edge", 2, 6'h00, 1'b1, 1'b1, 1'b1, 6'b0);
    apply("R6 powerdown", 3, 6'h11, 1'b1, 1'b0, 1'b1, 6'b0);
    apply("R6 powerdown oe low", 3, 6'h11, 1'b1, 1'b0, 1'b0, 6'b110011);
    apply("R7 outputs off", 3, 6'h11, 1'b1, 1'b1, 1'b0, 6'b0);
    apply("R9 resume", 3, 6'h11, 1'b1, 1'b1, 1'b1, 6'b0);
    apply("R8 partial unlock", 3, 6'h11, 1'b1, 1'b1, 1'b1, 6'b000101);
    apply("R8 other unlock", 7, 6'h22, 1'b1, 1'b1, 1'b1, 6'b111000);
    apply("R9 off then hold", 0, 6'h3E, 1'b1, 1'b1, 1'b0, 6'b0);
    apply("R9 resume sel0", 0, 6'h3E, 1'b1, 1'b1, 1'b1, 6'b0);
    repeat (3) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule